// File: doc/BRIEF.md
# Phase-Array Jitter Statistics Engine

This block reduces the per-cycle output of an on-die array phase detector to jitter statistics. The array has a centre element with an equal number of elements on either side. Each element has a larger built-in phase offset than the one before it, so a clean clock edge produces a thermometer pattern across the array. The block finds the single transition in that pattern by XORing adjacent samples and rejects any pattern that is not a clean thermometer. It then turns the transition position into a bin number.

A mode input selects what the block does with each legal bin. In histogram mode it accumulates an occurrence count per bin. In graph mode it stores the bin sequence in time order into a capture buffer, which freezes once it is full. In both modes the centre element supplies an up/down decision to a digital low-pass filter. The filter emits single increment or decrement pulses, and those pulses steer a reference position counter. Software-side reading uses two combinational indexed read ports. A synchronous clear input starts a new measurement.

Top module: `jhd_top`

## Requirements
- R1: Sample bit 0 carries the smallest offset. A legal pattern is k ones in bits 0..k-1 followed by zeros, and it is assigned bin k. Pattern 0x00FF (the centre element, bit 7, is the last one) is bin 8.
- R2: The all-zeros pattern is bin 0 and the all-ones pattern (0x7FFF) is bin 15.
- R3: Every valid sample whose pattern is not legal adds one to the error count and adds nothing to any bin or to the capture buffer.
- R4: With mode_graph low, each valid legal sample adds one to its bin's count. The count can be read on hist_rd_cnt two clock edges after the sample is taken. With mode_graph high, no bin count changes.
- R5: Bin counts and the error count saturate at 2^16-1.
- R6: With mode_graph high, valid legal samples are written to capture entries 0, 1, 2, ... in arrival order, and each entry can be read on graph_rd_bin.
- R7: After 64 entries are written, graph_done rises and stays high. Further samples do not change any entry.
- R8: Each valid sample counts +1 into the filter if bit 7 is 1 and -1 if it is 0. When the net count reaches +8, lpf_up_pulse is high for one cycle and the net count returns to zero. When it reaches -8, lpf_dn_pulse is high for one cycle and the net count returns to zero.
- R9: ref_pos resets to 128. It rises by one with each up pulse and falls by one with each down pulse, and it saturates at 0 and 255.
- R10: clr empties all bin counts and the error count, rewinds the capture buffer, lowers graph_done, zeroes the filter and returns ref_pos to 128.
- R11: After reset all counts read zero, graph_done and both pulses are low, and ref_pos is 128.
- R12: Samples with smp_vld low have no effect on any count, the buffer or the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample qualifier |
| smp_bits | input | 15 | Array phase detector samples, bit 0 = smallest offset |
| mode_graph | input | 1 | 0 = histogram, 1 = time-series capture |
| clr | input | 1 | Synchronous clear of all statistics |
| hist_rd_bin | input | 4 | Bin selected for readout |
| hist_rd_cnt | output | 16 | Count of the selected bin |
| err_cnt | output | 16 | Number of illegal patterns seen |
| graph_rd_idx | input | 6 | Capture entry selected for readout |
| graph_rd_bin | output | 4 | Bin stored at the selected entry |
| graph_done | output | 1 | Capture buffer full |
| lpf_up_pulse | output | 1 | Filter increment command |
| lpf_dn_pulse | output | 1 | Filter decrement command |
| ref_pos | output | 8 | Reference tracking position |

## Verification
The embedded properties assume that clr is held low for the whole of a measurement, because a clear is the only event that may release a saturated counter or a frozen buffer. They also assume that clr is low in the first cycle after reset. The stimulus asserts clr only between phases, when the pipeline is idle, and keeps mode_graph constant within each phase. The sweep drives every one of the 32768 possible sample words back to back, so every illegal shape as well as every legal one reaches the decoder.

// File: rtl/jhd_pkg.sv
package jhd_pkg;
   typedef enum logic {
      JH_HIST  = 1'b0,
      JH_GRAPH = 1'b1
   } jh_mode_e;

   function automatic int unsigned jh_bin_bits(input int unsigned side);
      return $clog2(2 * side + 2);
   endfunction
endpackage

// File: rtl/jhd_decode.sv
module jhd_decode #(
   parameter int unsigned SIDE  = 7,
   parameter int unsigned BIN_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_vld,
   input  logic [2*SIDE:0]       in_bits,
   output logic                  d_vld,
   output logic                  d_legal,
   output logic [BIN_W-1:0]      d_bin,
   output logic                  d_centre
);
   localparam int unsigned N  = 2 * SIDE + 1;
   localparam int unsigned CW = $clog2(N) + 1;

   logic [N-2:0]     edge_v;
   logic [CW-1:0]    n_edges;
   logic             legal;
   logic [BIN_W-1:0] enc;

   genvar g;
   generate
      for (g = 0; g < N - 1; g++) begin : g_xor
         assign edge_v[g] = in_bits[g] ^ in_bits[g+1];
      end
   endgenerate

   always_comb begin
      n_edges = CW'($countones(edge_v));
      legal   = (n_edges == '0) || ((n_edges == CW'(1)) && in_bits[0]);
      enc     = '0;
      for (int i = 0; i < N - 1; i++) begin
         if (edge_v[i]) enc = BIN_W'(i + 1);
      end
      if (n_edges == '0) enc = in_bits[0] ? BIN_W'(N) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_vld    <= 1'b0;
         d_legal  <= 1'b0;
         d_bin    <= '0;
         d_centre <= 1'b0;
      end else begin
         d_vld    <= in_vld;
         d_legal  <= legal;
         d_bin    <= enc;
         d_centre <= in_bits[SIDE];
      end
   end
endmodule

// File: rtl/jhd_hist.sv
module jhd_hist #(
   parameter int unsigned NBINS = 16,
   parameter int unsigned BIN_W = 4,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cnt_en,
   input  logic             s_vld,
   input  logic             s_legal,
   input  logic [BIN_W-1:0] s_bin,
   input  logic [BIN_W-1:0] rd_bin,
   output logic [CNT_W-1:0] rd_cnt,
   output logic [CNT_W-1:0] err_cnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [CNT_W-1:0] cnt_q [NBINS];

   genvar b;
   generate
      for (b = 0; b < NBINS; b++) begin : g_bin
         logic hit;
         assign hit = s_vld && s_legal && cnt_en && (s_bin == BIN_W'(b));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt_q[b] <= '0;
            else if (clr)                     cnt_q[b] <= '0;
            else if (hit && cnt_q[b] != CMAX) cnt_q[b] <= cnt_q[b] + 1'b1;
         end
         p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[b] == CMAX && !clr) |=> (cnt_q[b] == CMAX));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          err_cnt <= '0;
      else if (clr)                                        err_cnt <= '0;
      else if (s_vld && !s_legal && err_cnt != CMAX)       err_cnt <= err_cnt + 1'b1;
   end

   always_comb begin
      rd_cnt = '0;
      for (int i = 0; i < NBINS; i++) begin
         if (rd_bin == BIN_W'(i)) rd_cnt = cnt_q[i];
      end
   end

   p_err_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt == CMAX && !clr) |=> (err_cnt == CMAX));
endmodule

// File: rtl/jhd_graph.sv
module jhd_graph #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned BIN_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     cap_en,
   input  logic                     s_vld,
   input  logic                     s_legal,
   input  logic [BIN_W-1:0]         s_bin,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [BIN_W-1:0]         rd_bin,
   output logic                     done
);
   localparam int unsigned IDX_W = $clog2(DEPTH);

   logic [BIN_W-1:0] mem_q [DEPTH];
   logic [IDX_W-1:0] ptr_q;
   logic             wr;

   assign wr = s_vld && s_legal && cap_en && !done && !clr;

   always_ff @(posedge clk) begin
      if (wr) mem_q[ptr_q] <= s_bin;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         done  <= 1'b0;
      end else if (clr) begin
         ptr_q <= '0;
         done  <= 1'b0;
      end else if (wr) begin
         if (ptr_q == IDX_W'(DEPTH - 1)) done  <= 1'b1;
         else                            ptr_q <= ptr_q + 1'b1;
      end
   end

   assign rd_bin = mem_q[rd_idx];

   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> done);
   p_ptr_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> $stable(ptr_q));
endmodule

// File: rtl/jhd_lpf.sv
module jhd_lpf #(
   parameter int unsigned THRESH = 8,
   parameter int unsigned REF_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             s_vld,
   input  logic             s_up,
   output logic             up_pulse,
   output logic             dn_pulse,
   output logic [REF_W-1:0] ref_pos
);
   localparam int unsigned ACC_W = $clog2(THRESH) + 2;
   localparam logic [ACC_W-1:0] POS = ACC_W'(THRESH);
   localparam logic [ACC_W-1:0] NEG = '0 - POS;
   localparam logic [REF_W-1:0] MID = REF_W'(1) << (REF_W - 1);
   localparam logic [REF_W-1:0] RMAX = '1;

   logic [ACC_W-1:0] acc_q, acc_nx;
   logic             hit_pos, hit_neg;

   always_comb begin
      acc_nx  = s_up ? acc_q + 1'b1 : acc_q - 1'b1;
      hit_pos = s_vld && (acc_nx == POS);
      hit_neg = s_vld && (acc_nx == NEG);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         up_pulse <= 1'b0;
         dn_pulse <= 1'b0;
         ref_pos  <= MID;
      end else if (clr) begin
         acc_q    <= '0;
         up_pulse <= 1'b0;
         dn_pulse <= 1'b0;
         ref_pos  <= MID;
      end else begin
         up_pulse <= hit_pos;
         dn_pulse <= hit_neg;
         if (hit_pos || hit_neg) acc_q <= '0;
         else if (s_vld)         acc_q <= acc_nx;
         if (hit_pos && ref_pos != RMAX) ref_pos <= ref_pos + 1'b1;
         if (hit_neg && ref_pos != '0)   ref_pos <= ref_pos - 1'b1;
      end
   end

   p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_pulse && dn_pulse));
   p_ref_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_pulse && !dn_pulse && !$past(clr)) |-> $stable(ref_pos));
endmodule

// File: rtl/jhd_top.sv
module jhd_top #(
   parameter int unsigned SIDE        = 7,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned GRAPH_DEPTH = 64,
   parameter int unsigned LPF_THRESH  = 8,
   parameter int unsigned REF_W       = 8,
   localparam int unsigned SMP_N      = 2 * SIDE + 1,
   localparam int unsigned NBINS      = SMP_N + 1,
   localparam int unsigned BIN_W      = jhd_pkg::jh_bin_bits(SIDE),
   localparam int unsigned IDX_W      = $clog2(GRAPH_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic [SMP_N-1:0] smp_bits,
   input  logic             mode_graph,
   input  logic             clr,
   input  logic [BIN_W-1:0] hist_rd_bin,
   output logic [CNT_W-1:0] hist_rd_cnt,
   output logic [CNT_W-1:0] err_cnt,
   input  logic [IDX_W-1:0] graph_rd_idx,
   output logic [BIN_W-1:0] graph_rd_bin,
   output logic             graph_done,
   output logic             lpf_up_pulse,
   output logic             lpf_dn_pulse,
   output logic [REF_W-1:0] ref_pos
);
   import jhd_pkg::*;

   generate
      if (SIDE < 1)        begin : g_bad_side  $error("SIDE must be at least 1");        end
      if (GRAPH_DEPTH < 2) begin : g_bad_depth $error("GRAPH_DEPTH must be at least 2"); end
      if (LPF_THRESH < 2)  begin : g_bad_thr   $error("LPF_THRESH must be at least 2");  end
      if (REF_W < 2)       begin : g_bad_ref   $error("REF_W must be at least 2");       end
   endgenerate

   jh_mode_e         mode;
   logic             d_vld, d_legal, d_centre;
   logic [BIN_W-1:0] d_bin;

   assign mode = jh_mode_e'(mode_graph);

   jhd_decode #(.SIDE(SIDE), .BIN_W(BIN_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .in_vld(smp_vld && !clr), .in_bits(smp_bits),
      .d_vld(d_vld), .d_legal(d_legal), .d_bin(d_bin), .d_centre(d_centre));

   jhd_hist #(.NBINS(NBINS), .BIN_W(BIN_W), .CNT_W(CNT_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(mode == JH_HIST),
      .s_vld(d_vld), .s_legal(d_legal), .s_bin(d_bin),
      .rd_bin(hist_rd_bin), .rd_cnt(hist_rd_cnt), .err_cnt(err_cnt));

   jhd_graph #(.DEPTH(GRAPH_DEPTH), .BIN_W(BIN_W)) u_graph (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cap_en(mode == JH_GRAPH),
      .s_vld(d_vld), .s_legal(d_legal), .s_bin(d_bin),
      .rd_idx(graph_rd_idx), .rd_bin(graph_rd_bin), .done(graph_done));

   jhd_lpf #(.THRESH(LPF_THRESH), .REF_W(REF_W)) u_lpf (
      .clk(clk), .rst_n(rst_n), .clr(clr), .s_vld(d_vld), .s_up(d_centre),
      .up_pulse(lpf_up_pulse), .dn_pulse(lpf_dn_pulse), .ref_pos(ref_pos));
endmodule

// File: tb/sim_jhd_top.sv
module sim_jhd_top;
   localparam int CLK_PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [14:0] smp_bits = '0;
   logic        mode_graph = 1'b0;
   logic        clr = 1'b0;
   logic [3:0]  hist_rd_bin = '0;
   logic [15:0] hist_rd_cnt, err_cnt;
   logic [5:0]  graph_rd_idx = '0;
   logic [3:0]  graph_rd_bin;
   logic        graph_done, lpf_up_pulse, lpf_dn_pulse;
   logic [7:0]  ref_pos;

   int vectors = 0, fails = 0;
   int n_up = 0, n_dn = 0, m_up = 0, m_dn = 0, m_acc = 0, m_ref = 128;
   int exp_bins [64];
   int n_exp = 0, n_bad = 0;

   always #(CLK_PER/2) clk = ~clk;

   jhd_top u0 (.*);

   always @(negedge clk) if (rst_n) begin
      if (lpf_up_pulse) n_up++;
      if (lpf_dn_pulse) n_dn++;
   end

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int legal_bin(input int p);
      for (int k = 0; k <= 15; k++) if (p == (1 << k) - 1) return k;
      return -1;
   endfunction

   task automatic model_lpf(input int p);
      m_acc += p[7] ? 1 : -1;
      if (m_acc == 8)  begin m_up++; m_acc = 0; if (m_ref < 255) m_ref++; end
      if (m_acc == -8) begin m_dn++; m_acc = 0; if (m_ref > 0)   m_ref--; end
   endtask

   task automatic drive(input int p);
      @(negedge clk);
      smp_bits = 15'(p);
      smp_vld  = 1'b1;
      model_lpf(p);
   endtask

   task automatic settle();
      @(negedge clk); smp_vld = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_clr();
      @(negedge clk); smp_vld = 1'b0; clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      @(negedge clk);
      m_acc = 0; m_ref = 128; m_up = 0; m_dn = 0; n_up = 0; n_dn = 0;
   endtask

   function automatic int rd_hist_now();
      return int'(hist_rd_cnt);
   endfunction

   task automatic hist_chk(input string req, input int b, input int exp);
      hist_rd_bin = 4'(b); #1;
      chk(req, rd_hist_now(), exp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      for (int b = 0; b < 16; b++) hist_chk("R11 bin", b, 0);
      chk("R11 err", int'(err_cnt), 0);
      chk("R11 done", int'(graph_done), 0);
      chk("R11 ref", int'(ref_pos), 128);
      chk("R11 pulses", int'(lpf_up_pulse) + int'(lpf_dn_pulse), 0);

      // Exhaustive sweep of every sample word in histogram mode: R1 R2 R3 R4 R8 R9
      for (int p = 0; p < 32768; p++) drive(p);
      settle();
      for (int b = 0; b < 16; b++)
         hist_chk((b == 0 || b == 15) ? "R2 end bin" : "R1 bin", b, 1);
      chk("R3 err count", int'(err_cnt), 32768 - 16);
      chk("R8 up pulses", n_up, m_up);
      chk("R8 down pulses", n_dn, m_dn);
      chk("R9 ref", int'(ref_pos), m_ref);

      // R12 unqualified samples are ignored
      for (int p = 0; p < 20; p++) begin
         @(negedge clk); smp_bits = 15'(p * 7); smp_vld = 1'b0;
      end
      settle();
      hist_chk("R12 bin0", 0, 1);
      hist_chk("R12 bin3", 3, 1);
      chk("R12 err", int'(err_cnt), 32768 - 16);
      chk("R12 ref", int'(ref_pos), m_ref);

      // R1 centre bin, R4 latency of two edges
      @(negedge clk); smp_bits = 15'h00FF; smp_vld = 1'b1;
      @(negedge clk); smp_vld = 1'b0; hist_rd_bin = 4'd8; #1;
      chk("R4 one edge later", rd_hist_now(), 1);
      @(negedge clk); #1;
      chk("R1 centre bin 8", rd_hist_now(), 2);
      model_lpf(15'h00FF);

      // R10 clear
      do_clr();
      for (int b = 0; b < 16; b++) hist_chk("R10 bin", b, 0);
      chk("R10 err", int'(err_cnt), 0);
      chk("R10 ref", int'(ref_pos), 128);

      // R5 saturation, R9 ref saturation
      for (int i = 0; i < 65540; i++) drive(15'h00FF);
      for (int i = 0; i < 3; i++) drive(15'h0F0F);
      settle();
      hist_chk("R5 saturated bin", 8, 65535);
      chk("R9 ref top", int'(ref_pos), 255);
      chk("R8 up pulses sat", n_up, m_up);
      chk("R3 err after sat", int'(err_cnt), 3);

      // Graph mode: R6 R7 R3
      do_clr();
      mode_graph = 1'b1;
      for (int j = 0; n_exp < 63; j++) begin
         if (j % 7 == 3) begin drive(15'h0F0F); n_bad++; end
         else begin
            drive((1 << ((j * 5) % 16)) - 1);
            exp_bins[n_exp] = (j * 5) % 16; n_exp++;
         end
      end
      settle();
      chk("R7 not done at 63", int'(graph_done), 0);
      drive((1 << 11) - 1); exp_bins[63] = 11;
      for (int j = 0; j < 10; j++) drive((1 << (j % 4)) - 1);
      settle();
      chk("R7 done", int'(graph_done), 1);
      for (int i = 0; i < 64; i++) begin
         graph_rd_idx = 6'(i); #1;
         chk("R6 entry", int'(graph_rd_bin), exp_bins[i]);
      end
      chk("R3 graph err", int'(err_cnt), n_bad);
      hist_chk("R4 graph mode no count", 0, 0);
      hist_chk("R4 graph mode no count", 11, 0);
      chk("R9 ref graph", int'(ref_pos), m_ref);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule